// File: doc/BRIEF.md
# Interleaved Biphasic Stimulation Pulse Sequencer

This block turns per-channel stimulation amplitudes into a strictly serialized stream of biphasic current pulses for an electrode array. Each of up to sixteen channels has its own pacing counter. When a counter expires, the channel becomes pending. A single shared sequencer serves pending channels one at a time. For each one it drives a cathodic phase, a one-cycle gap and an anodic phase, all at the same amplitude, on a parallel stimulus interface. It then sends two 16-bit descriptors, one per phase, over a serial transmit port.

A host programs the pacing period, the phase duration, the set of active channels and a table that maps each channel to an electrode. A separate write port loads the latest compressed 8-bit amplitude for each channel. The sequencer takes the amplitude and the electrode when it grants a channel. A bypass input gives the serial pins to an external controller. While bypass is high, pacing, pulse timing and shifting all pause, so the host can send its own pulse data.

Top module: `stim_pulse_sequencer`

## Requirements
- R1: After reset `stim_phase` is 0, `spi_cs_n` is 1, `spi_sclk` is 0 and `tx_done` is 0. No channel is active until the active mask (address 2) is written.
- R2: A pulse is `stim_phase`=1 (cathodic) for D cycles, then 0 for exactly one cycle, then 2 (anodic) for D cycles, then 0. D is the duration register (address 1). A duration of 0 behaves as 1. Code 3 never appears.
- R3: A lone active channel starts a pulse every P+1 cycles, where P is the period register (address 0).
- R4: Channels that become pending together are served in ascending channel order.
- R5: When another channel is pending, its cathodic phase begins exactly two cycles after the cycle of the previous pulse's second `tx_done`. Pulses never overlap each other or a serial transfer.
- R6: A channel whose bit in the active mask is 0 never pulses and takes no time slot.
- R7: `stim_elec` equals the map entry of the served channel (map entry for channel i at address 16+i, reset value i). `stim_amp` equals that channel's last written amplitude, and it is the same in both phases.
- R8: Each pulse produces two serial words, MSB first, each framed by `spi_cs_n` low for 32 cycles with the bit valid at the rising `spi_sclk`. A word is {2'b00, electrode[3:0], phase[1:0], amplitude[7:0]}. The first word carries phase 01 and the second carries phase 10.
- R9: `tx_done` pulses for one cycle, in the cycle where `spi_cs_n` returns high after each word.
- R10: While `bypass` is 1, the serial pins follow `host_sclk`, `host_mosi` and `host_cs_n`. Stimulation and pacing hold, and `tx_done` stays 0. Once `bypass` falls, pacing resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | 0 period, 1 duration, 2 active mask, 16+i map entry of channel i |
| cfg_wdata | input | 16 | Configuration write data |
| amp_we | input | 1 | Amplitude write strobe |
| amp_ch | input | 4 | Channel of the amplitude write |
| amp_data | input | 8 | Compressed amplitude |
| bypass | input | 1 | Give serial port to the host, pause sequencing |
| host_sclk | input | 1 | Host serial clock (used in bypass) |
| host_mosi | input | 1 | Host serial data (used in bypass) |
| host_cs_n | input | 1 | Host chip select (used in bypass) |
| stim_phase | output | 2 | 0 idle/gap, 1 cathodic, 2 anodic |
| stim_elec | output | 4 | Electrode of the current pulse |
| stim_amp | output | 8 | Amplitude of the current pulse |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data |
| spi_cs_n | output | 1 | Serial chip select, active low |
| tx_done | output | 1 | One-cycle strobe when a word completes |

## Verification
A corrupted pacing counter or pending flag shows up as a pulse start that is off its P+1 grid, or as a missing pulse, within one period. A wrong grant shows up at the next pulse as an electrode out of ascending order or a slot spent on an inactive channel. A stuck phase timer shows up within D+1 cycles as a wrong phase length, a missing gap or a phase code of 3. Shift-register or framing faults show up in the very next word as a changed bit, a chip-select window other than 32 cycles, or a misplaced done strobe.

// File: rtl/stim_pkg.sv
package stim_pkg;

    localparam int unsigned ELEC_W = 4;
    localparam int unsigned AMP_W  = 8;
    localparam int unsigned WORD_W = 16;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CATH,
        SQ_GAP,
        SQ_ANOD,
        SQ_TX_A,
        SQ_TX_B
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_NONE = 2'b00,
        PH_CATH = 2'b01,
        PH_ANOD = 2'b10
    } phase_t;

    typedef struct packed {
        logic [ELEC_W-1:0] elec;
        logic [AMP_W-1:0]  amp;
    } pulse_desc_t;

    function automatic logic [WORD_W-1:0] pack_word(pulse_desc_t d, phase_t ph);
        pack_word = WORD_W'({d.elec, ph, d.amp});
    endfunction

endpackage

// File: rtl/stim_pacer.sv
module stim_pacer #(
    parameter int unsigned NUM_CH   = 16,
    parameter int unsigned PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic [PERIOD_W-1:0] period,
    input  logic [NUM_CH-1:0]   active,
    input  logic [NUM_CH-1:0]   grant,
    output logic [NUM_CH-1:0]   pending
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [PERIOD_W-1:0] cnt_q;
        logic                pend_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q  <= '0;
                pend_q <= 1'b0;
            end else if (run) begin
                if (!active[g]) begin
                    cnt_q  <= period;
                    pend_q <= 1'b0;
                end else if (cnt_q == '0) begin
                    cnt_q  <= period;
                    pend_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                    if (grant[g]) pend_q <= 1'b0;
                end
            end
        end

        assign pending[g] = pend_q;
    end

endmodule

// File: rtl/stim_sequencer.sv
module stim_sequencer
    import stim_pkg::*;
#(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned DUR_W  = 8,
    localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              run,
    input  logic [NUM_CH-1:0]                 pending,
    input  logic [DUR_W-1:0]                  dur,
    input  logic [NUM_CH-1:0][ELEC_W-1:0]     elec_map,
    input  logic [NUM_CH-1:0][AMP_W-1:0]      amp_tab,
    input  logic                              tx_done,
    output logic [NUM_CH-1:0]                 grant,
    output logic [1:0]                        stim_phase,
    output logic [ELEC_W-1:0]                 stim_elec,
    output logic [AMP_W-1:0]                  stim_amp,
    output logic                              tx_start,
    output logic [WORD_W-1:0]                 tx_word
);

    seq_state_t         state_q;
    logic [DUR_W-1:0]   tcnt_q;
    pulse_desc_t        cur_q;
    logic               start_q;
    logic               pick_any;
    logic [CH_W-1:0]    pick_idx;
    logic [DUR_W-1:0]   dur_ld;

    assign dur_ld = (dur == '0) ? '0 : dur - 1'b1;

    always_comb begin
        pick_any = 1'b0;
        pick_idx = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (pending[i]) begin
                pick_any = 1'b1;
                pick_idx = CH_W'(i);
            end
        end
        grant = '0;
        if (state_q == SQ_IDLE && run && pick_any) grant[pick_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            tcnt_q  <= '0;
            cur_q   <= '0;
            start_q <= 1'b0;
        end else if (run) begin
            start_q <= 1'b0;
            unique case (state_q)
                SQ_IDLE: if (pick_any) begin
                    cur_q.elec <= elec_map[pick_idx];
                    cur_q.amp  <= amp_tab[pick_idx];
                    tcnt_q     <= dur_ld;
                    state_q    <= SQ_CATH;
                end
                SQ_CATH: begin
                    if (tcnt_q == '0) state_q <= SQ_GAP;
                    else              tcnt_q  <= tcnt_q - 1'b1;
                end
                SQ_GAP: begin
                    tcnt_q  <= dur_ld;
                    state_q <= SQ_ANOD;
                end
                SQ_ANOD: begin
                    if (tcnt_q == '0) begin
                        state_q <= SQ_TX_A;
                        start_q <= 1'b1;
                    end else begin
                        tcnt_q <= tcnt_q - 1'b1;
                    end
                end
                SQ_TX_A: if (tx_done) begin
                    state_q <= SQ_TX_B;
                    start_q <= 1'b1;
                end
                SQ_TX_B: if (tx_done) state_q <= SQ_IDLE;
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        stim_phase = PH_NONE;
        if (state_q == SQ_CATH) stim_phase = PH_CATH;
        if (state_q == SQ_ANOD) stim_phase = PH_ANOD;
    end

    assign stim_elec = (stim_phase != PH_NONE) ? cur_q.elec : '0;
    assign stim_amp  = (stim_phase != PH_NONE) ? cur_q.amp  : '0;
    assign tx_start  = start_q;
    assign tx_word   = pack_word(cur_q, (state_q == SQ_TX_B) ? PH_ANOD : PH_CATH);

endmodule

// File: rtl/stim_spi_tx.sv
module stim_spi_tx #(
    parameter int unsigned W = 16,
    localparam int unsigned CW = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         start,
    input  logic [W-1:0] word,
    output logic         sclk,
    output logic         mosi,
    output logic         cs_n,
    output logic         done
);

    logic          busy_q;
    logic          half_q;
    logic [CW-1:0] bit_q;
    logic [W-1:0]  sh_q;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            half_q <= 1'b0;
            bit_q  <= '0;
            sh_q   <= '0;
            done_q <= 1'b0;
        end else if (run) begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q <= 1'b1;
                    half_q <= 1'b0;
                    bit_q  <= '0;
                    sh_q   <= word;
                end
            end else if (!half_q) begin
                half_q <= 1'b1;
            end else begin
                half_q <= 1'b0;
                if (bit_q == CW'(W - 1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    bit_q <= bit_q + 1'b1;
                    sh_q  <= sh_q << 1;
                end
            end
        end
    end

    assign sclk = busy_q & half_q;
    assign mosi = busy_q & sh_q[W-1];
    assign cs_n = ~busy_q;
    assign done = done_q;

endmodule

// File: rtl/stim_pulse_sequencer.sv
module stim_pulse_sequencer
    import stim_pkg::*;
#(
    parameter int unsigned NUM_CH   = 16,
    parameter int unsigned PERIOD_W = 16,
    parameter int unsigned DUR_W    = 8,
    parameter int unsigned CFG_DW   = 16,
    localparam int unsigned CH_W    = $clog2(NUM_CH),
    localparam int unsigned CFG_AW  = CH_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    input  logic              amp_we,
    input  logic [CH_W-1:0]   amp_ch,
    input  logic [AMP_W-1:0]  amp_data,
    input  logic              bypass,
    input  logic              host_sclk,
    input  logic              host_mosi,
    input  logic              host_cs_n,
    output logic [1:0]        stim_phase,
    output logic [ELEC_W-1:0] stim_elec,
    output logic [AMP_W-1:0]  stim_amp,
    output logic              spi_sclk,
    output logic              spi_mosi,
    output logic              spi_cs_n,
    output logic              tx_done
);

    logic [PERIOD_W-1:0]               period_q;
    logic [DUR_W-1:0]                  dur_q;
    logic [NUM_CH-1:0]                 active_q;
    logic [NUM_CH-1:0][ELEC_W-1:0]     map_q;
    logic [NUM_CH-1:0][AMP_W-1:0]      amp_q;
    logic [NUM_CH-1:0]                 pending;
    logic [NUM_CH-1:0]                 grant;
    logic                              run;
    logic                              tx_start;
    logic [WORD_W-1:0]                 tx_word;
    logic                              int_sclk, int_mosi, int_cs_n, int_done;

    assign run = ~bypass;

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= PERIOD_W'(999);
            dur_q    <= DUR_W'(4);
            active_q <= '0;
            for (int i = 0; i < NUM_CH; i++) begin
                map_q[i] <= ELEC_W'(i);
                amp_q[i] <= '0;
            end
        end else begin
            if (cfg_we) begin
                if (cfg_addr[CFG_AW-1]) begin
                    map_q[cfg_addr[CH_W-1:0]] <= cfg_wdata[ELEC_W-1:0];
                end else begin
                    case (cfg_addr[CH_W-1:0])
                        CH_W'(0): period_q <= cfg_wdata[PERIOD_W-1:0];
                        CH_W'(1): dur_q    <= cfg_wdata[DUR_W-1:0];
                        CH_W'(2): active_q <= cfg_wdata[NUM_CH-1:0];
                        default: ;
                    endcase
                end
            end
            if (amp_we) amp_q[amp_ch] <= amp_data;
        end
    end

    stim_pacer #(.NUM_CH(NUM_CH), .PERIOD_W(PERIOD_W)) u_pacer (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .period  (period_q),
        .active  (active_q),
        .grant   (grant),
        .pending (pending)
    );

    stim_sequencer #(.NUM_CH(NUM_CH), .DUR_W(DUR_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .pending    (pending),
        .dur        (dur_q),
        .elec_map   (map_q),
        .amp_tab    (amp_q),
        .tx_done    (int_done),
        .grant      (grant),
        .stim_phase (stim_phase),
        .stim_elec  (stim_elec),
        .stim_amp   (stim_amp),
        .tx_start   (tx_start),
        .tx_word    (tx_word)
    );

    stim_spi_tx #(.W(WORD_W)) u_tx (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .start (tx_start),
        .word  (tx_word),
        .sclk  (int_sclk),
        .mosi  (int_mosi),
        .cs_n  (int_cs_n),
        .done  (int_done)
    );

    assign spi_sclk = bypass ? host_sclk : int_sclk;
    assign spi_mosi = bypass ? host_mosi : int_mosi;
    assign spi_cs_n = bypass ? host_cs_n : int_cs_n;
    assign tx_done  = int_done & ~bypass;

endmodule

// File: rtl/stim_pulse_sequencer_chk.sv
module stim_pulse_sequencer_chk (
    input logic       clk,
    input logic       rst,
    input logic       bypass,
    input logic [1:0] stim_phase,
    input logic       spi_cs_n,
    input logic       tx_done
);

    // R2: phase code 3 is never driven
    assert_phase_code_R2: assert property (@(posedge clk) disable iff (rst)
        stim_phase != 2'b11);

    // R2: anodic phase is entered only from a one-cycle gap after cathodic
    assert_biphasic_order_R2: assert property (@(posedge clk) disable iff (rst)
        (stim_phase == 2'b10 && $past(stim_phase) != 2'b10 && !$past(bypass) && !$past(bypass, 2))
        |-> ($past(stim_phase) == 2'b00 && $past(stim_phase, 2) == 2'b01));

    // R5: no serial transfer while a phase is driven
    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (rst)
        (stim_phase != 2'b00 && !bypass) |-> spi_cs_n);

    // R9: done follows the end of a chip-select window
    assert_done_after_word_R9: assert property (@(posedge clk) disable iff (rst)
        (tx_done && !$past(bypass)) |-> (spi_cs_n && !$past(spi_cs_n)));

    // R10: nothing moves while the host owns the port
    assert_bypass_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (bypass && $past(bypass)) |-> ($stable(stim_phase) && !tx_done));

endmodule

bind stim_pulse_sequencer stim_pulse_sequencer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bypass     (bypass),
    .stim_phase (stim_phase),
    .spi_cs_n   (spi_cs_n),
    .tx_done    (tx_done)
);

// File: tb/test_stim_pulse_sequencer.sv
module test_stim_pulse_sequencer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic       amp_we = 1'b0;
    logic [3:0] amp_ch = '0;
    logic [7:0] amp_data = '0;
    logic       bypass = 1'b0;
    logic       host_sclk = 1'b0, host_mosi = 1'b0, host_cs_n = 1'b1;
    logic [1:0] stim_phase;
    logic [3:0] stim_elec;
    logic [7:0] stim_amp;
    logic       spi_sclk, spi_mosi, spi_cs_n, tx_done;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    stim_pulse_sequencer i_stim_pulse_sequencer (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .amp_we(amp_we), .amp_ch(amp_ch), .amp_data(amp_data), .bypass(bypass),
        .host_sclk(host_sclk), .host_mosi(host_mosi), .host_cs_n(host_cs_n),
        .stim_phase(stim_phase), .stim_elec(stim_elec), .stim_amp(stim_amp),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .tx_done(tx_done)
    );

    // ---------------- monitors (sample at falling edge) ----------------
    int cyc = 0;
    int ev_n = 0, dn_n = 0, cs_n_cnt = 0, wd_n = 0;
    int ev_cyc [256];
    int ev_ph  [256];
    int ev_el  [256];
    int ev_amp [256];
    int dn_cyc [256];
    int cs_len [256];
    logic [15:0] words [256];
    int cur_cs = 0;
    logic [1:0] prev_ph = 2'b00;
    logic prev_sclk = 1'b0;
    logic [15:0] shreg = '0;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (stim_phase != prev_ph && ev_n < 256) begin
                ev_cyc[ev_n] = cyc; ev_ph[ev_n] = int'(stim_phase);
                ev_el[ev_n] = int'(stim_elec); ev_amp[ev_n] = int'(stim_amp);
                ev_n++;
            end
            if (tx_done && dn_n < 256) begin dn_cyc[dn_n] = cyc; dn_n++; end
            if (!bypass) begin
                if (spi_sclk && !prev_sclk) shreg = {shreg[14:0], spi_mosi};
                if (!spi_cs_n) cur_cs++;
                else if (cur_cs != 0) begin
                    if (wd_n < 256) begin
                        cs_len[wd_n] = cur_cs; words[wd_n] = shreg; wd_n++;
                    end
                    cur_cs = 0;
                end
            end
        end
        prev_ph = stim_phase;
        prev_sclk = spi_sclk;
    end

    // ---------------- pulse extraction ----------------
    int np;
    int p_start [64];
    int p_el [64];
    int p_amp [64];
    int p_amp2 [64];
    int p_l1 [64];
    int p_gap [64];
    int p_l2 [64];
    int p_shape_ok [64];

    task automatic analyze();
        np = 0;
        for (int i = 0; i + 3 < ev_n; i++) begin
            if (ev_ph[i] == 1 && np < 64) begin
                p_start[np] = ev_cyc[i];
                p_el[np]    = ev_el[i];
                p_amp[np]   = ev_amp[i];
                p_amp2[np]  = ev_amp[i+2];
                p_l1[np]    = ev_cyc[i+1] - ev_cyc[i];
                p_gap[np]   = ev_cyc[i+2] - ev_cyc[i+1];
                p_l2[np]    = ev_cyc[i+3] - ev_cyc[i+2];
                p_shape_ok[np] = (ev_ph[i+1] == 0 && ev_ph[i+2] == 2 && ev_ph[i+3] == 0) ? 1 : 0;
                np++;
            end
        end
    endtask

    task automatic clear_logs();
        ev_n = 0; dn_n = 0; wd_n = 0;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic cfg_write(input logic [4:0] a, input logic [15:0] d);
        step(1);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        step(1);
        cfg_we = 1'b0;
    endtask

    task automatic amp_write(input logic [3:0] ch, input logic [7:0] d);
        step(1);
        amp_we = 1'b1; amp_ch = ch; amp_data = d;
        step(1);
        amp_we = 1'b0;
    endtask

    function automatic logic [15:0] exp_word(input int el, input logic [1:0] ph, input int amp);
        return {2'b00, 4'(el), ph, 8'(amp)};
    endfunction

    // ---------------- scenarios ----------------
    task automatic t_reset();
        check(stim_phase == 2'b00, "R1 phase after reset", int'(stim_phase), 0);
        check(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R1 serial idle after reset",
              int'({spi_cs_n, spi_sclk}), 2);
        step(40);
        check(tx_done == 1'b0 && ev_n == 0, "R1 nothing active before mask write", ev_n, 0);
    endtask

    task automatic t_single_channel();
        clear_logs();
        cfg_write(5'd1, 16'd3);
        cfg_write(5'd0, 16'd299);
        cfg_write(5'd2, 16'h0004);
        step(1000);
        cfg_write(5'd2, 16'h0000);
        step(150);
        analyze();
        check(np >= 3, "R3 pulse count for lone channel", np, 3);
        if (np >= 3) begin
            check(p_shape_ok[0] == 1 && p_l1[0] == 3 && p_gap[0] == 1 && p_l2[0] == 3,
                  "R2 phase lengths D=3", p_l1[0] * 100 + p_gap[0] * 10 + p_l2[0], 313);
            check(p_start[1] - p_start[0] == 300, "R3 pulse spacing", p_start[1] - p_start[0], 300);
            check(p_start[2] - p_start[1] == 300, "R3 pulse spacing 2", p_start[2] - p_start[1], 300);
            check(p_el[0] == 13, "R7 electrode from map", p_el[0], 13);
            check(p_amp[0] == 'h32 && p_amp2[0] == 'h32, "R7 amplitude both phases", p_amp2[0], 'h32);
        end
        check(wd_n == 2 * np, "R8 two words per pulse", wd_n, 2 * np);
        check(words[0] == exp_word(13, 2'b01, 'h32), "R8 first word", int'(words[0]),
              int'(exp_word(13, 2'b01, 'h32)));
        check(words[1] == exp_word(13, 2'b10, 'h32), "R8 second word", int'(words[1]),
              int'(exp_word(13, 2'b10, 'h32)));
        check(cs_len[0] == 32 && cs_len[1] == 32, "R8 chip-select window", cs_len[1], 32);
        check(dn_n == wd_n, "R9 one done per word", dn_n, wd_n);
    endtask

    task automatic t_zero_duration();
        clear_logs();
        cfg_write(5'd1, 16'd0);
        cfg_write(5'd0, 16'd199);
        cfg_write(5'd2, 16'h0080);
        step(260);
        cfg_write(5'd2, 16'h0000);
        step(150);
        analyze();
        check(np == 1, "R2 one pulse with D=0", np, 1);
        check(np >= 1 && p_shape_ok[0] == 1 && p_l1[0] == 1 && p_gap[0] == 1 && p_l2[0] == 1,
              "R2 D=0 acts as D=1", p_l1[0] * 100 + p_gap[0] * 10 + p_l2[0], 111);
        check(p_el[0] == 8, "R7 electrode ch7", p_el[0], 8);
    endtask

    task automatic t_order_and_skip();
        clear_logs();
        cfg_write(5'd1, 16'd2);
        cfg_write(5'd0, 16'd999);
        cfg_write(5'd2, 16'h0222);
        step(1400);
        cfg_write(5'd2, 16'h0000);
        step(150);
        analyze();
        check(np == 3, "R4 three pulses in one round", np, 3);
        if (np == 3) begin
            check(p_el[0] == 14 && p_el[1] == 10 && p_el[2] == 6, "R4 ascending channel order",
                  p_el[0] * 256 + p_el[1] * 16 + p_el[2], 14 * 256 + 10 * 16 + 6);
            check(dn_n >= 4 && p_start[1] == dn_cyc[1] + 2, "R5 next pulse two cycles after done",
                  p_start[1] - dn_cyc[1], 2);
            check(dn_n >= 4 && p_start[2] == dn_cyc[3] + 2, "R6 inactive channels take no slot",
                  p_start[2] - dn_cyc[3], 2);
        end
        begin
            int bad = 0;
            for (int k = 0; k < np; k++) if (p_el[k] == 12 || p_el[k] == 11) bad++;
            check(bad == 0, "R6 inactive channels never pulse", bad, 0);
        end
    endtask

    task automatic t_amp_update();
        clear_logs();
        amp_write(4'd1, 8'hC5);
        cfg_write(5'd1, 16'd5);
        cfg_write(5'd0, 16'd99);
        cfg_write(5'd2, 16'h0002);
        step(120);
        cfg_write(5'd2, 16'h0000);
        step(150);
        analyze();
        check(np == 1 && p_amp[0] == 'hC5 && p_amp2[0] == 'hC5, "R7 latest amplitude used",
              p_amp2[0], 'hC5);
        check(np == 1 && p_l1[0] == 5 && p_l2[0] == 5, "R2 phase lengths D=5", p_l2[0], 5);
        check(words[0] == exp_word(14, 2'b01, 'hC5), "R8 word after amplitude update",
              int'(words[0]), int'(exp_word(14, 2'b01, 'hC5)));
    endtask

    task automatic t_bypass();
        int mism = 0;
        clear_logs();
        cfg_write(5'd0, 16'd50);
        cfg_write(5'd1, 16'd2);
        step(2);
        bypass = 1'b1;
        cfg_write(5'd2, 16'h0001);
        for (int k = 0; k < 200; k++) begin
            step(1);
            host_sclk = k[0]; host_mosi = k[2]; host_cs_n = k[4];
            #1;
            if (spi_sclk != host_sclk || spi_mosi != host_mosi || spi_cs_n != host_cs_n) mism++;
        end
        check(mism == 0, "R10 pins follow host", mism, 0);
        check(ev_n == 0 && dn_n == 0, "R10 no activity in bypass", ev_n + dn_n, 0);
        host_cs_n = 1'b1; host_sclk = 1'b0; host_mosi = 1'b0;
        bypass = 1'b0;
        step(100);
        cfg_write(5'd2, 16'h0000);
        step(150);
        analyze();
        check(np >= 1 && p_el[0] == 15, "R10 pacing resumes after bypass", np, 1);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        t_reset();
        for (int i = 0; i < 16; i++) begin
            cfg_write(5'(16 + i), 16'(15 - i));
            amp_write(4'(i), 8'(8'h30 + i));
        end
        t_single_channel();
        t_zero_duration();
        t_order_and_skip();
        t_amp_update();
        t_bypass();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule